// File: doc/BRIEF.md
# Translation Stream Control Register Bank

This block is the software-visible control surface of a DMA address-translation unit that serves sixteen DMA stream IDs. It is a bank of 32-bit registers behind a request/response port. For each stream it holds a control word that enables translation or asks for bypass, and four page-table base entries. The bank also has a stream-enable mask and a read-only parameter word. The decoded contents drive the rest of the translation unit as plain per-stream vectors.

The bank also starts TLB invalidations. A flush-scope mask register chooses which streams a flush affects. Writing the start bit of the flush command register sends a one-cycle request, together with a snapshot of that mask, to the TLB. The command stays busy until the TLB returns a done pulse, and software polls the busy bit to know when the flush is over.

Requests use valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Writes take effect on that edge and produce no response. Each read produces exactly one response, offered on `rsp_valid`. The response slot holds one entry, and `req_ready` is low while an unconsumed response is stalled by a low `rsp_ready`. A stalled response keeps its data unchanged until the receiver accepts it.

Top module: `xlat_stream_regs`

## Requirements
- R1: After reset all stored registers and all control outputs are zero, `inv_req` is low, and a read of offset 0x004 returns `cfg_bypass_ok` in bit 0 with zeros elsewhere.
- R2: The control word of stream s is at offset 0x100+4*s. Bit 7 drives `xlate_en[s]`, bit 8 drives `bypass_xlate[s]` and bit 12 drives `bypass_pref[s]`. All other bits read back as zero, and writing zero clears all three outputs for that stream.
- R3: Base entry i (0..3) of stream s is at offset 0x200+16*s+4*i. It stores all 32 bits (bit 31 = entry valid, bits 30:0 = table address >> 12) and appears on `base_flat[(s*4+i)*32 +: 32]`.
- R4: Offset 0x0FC holds the stream-enable mask in bits 15:0, driven on `stream_en`; upper bits read back as zero.
- R5: Offset 0x034 holds the flush-scope mask in bits 15:0. The mask is copied to `inv_mask` on the edge at which a flush starts.
- R6: When no flush is busy, a write to offset 0x020 with bit 20 set starts a flush. `inv_req` is high for exactly the next cycle, and bit 2 of offset 0x020 reads 1 from then on.
- R7: Busy clears on the edge at which `inv_done` is sampled high while busy, so a read issued after that reads bit 2 as 0. `inv_done` while idle has no effect.
- R8: A flush start write while busy is ignored: no new `inv_req` pulse, `inv_mask` is unchanged, and busy remains set.
- R9: Offset 0x004 is read-only, and writes to it have no effect.
- R10: Reads of unmapped or non-word-aligned addresses return zero, and writes to them change no register.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. Read responses come back in request order, and a stalled response holds `rsp_valid` and `rsp_rdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass_ok | input | 1 | Configuration strap reported in the parameter word |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumer ready |
| rsp_rdata | output | 32 | Read response data |
| xlate_en | output | 16 | Per-stream translation enable |
| bypass_xlate | output | 16 | Per-stream translation bypass |
| bypass_pref | output | 16 | Per-stream prefetch-path bypass |
| stream_en | output | 16 | Stream-enable mask |
| base_flat | output | 2048 | All base entries, entry s*4+i at bits (s*4+i)*32 |
| inv_req | output | 1 | One-cycle TLB invalidate request |
| inv_mask | output | 16 | Streams affected by the current invalidate |
| inv_done | input | 1 | TLB invalidate completion pulse |

## Verification
The hardest state to reach is a second flush start that arrives while the first flush is still waiting for the TLB. The mask has also been rewritten in between, so a design that wrongly accepts the second start would show a new mask. The bench holds `inv_done` low on purpose, writes a different scope mask, issues the second start, and only then pulses `inv_done`. Read responses are also stalled with a periodic low `rsp_ready` while reads are queued back to back. Together these check ordering and hold behaviour against the scoreboard.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XS_NSTREAM = 16;
  localparam int unsigned XS_NBASE   = 4;
  localparam int unsigned XS_DW      = 32;
  localparam int unsigned XS_AW      = 12;

  localparam int unsigned OFF_PARAM      = 'h004;
  localparam int unsigned OFF_FLUSH_CMD  = 'h020;
  localparam int unsigned OFF_FLUSH_MASK = 'h034;
  localparam int unsigned OFF_STREAM_EN  = 'h0FC;
  localparam int unsigned OFF_CTRL       = 'h100;
  localparam int unsigned OFF_BASE       = 'h200;

  localparam int unsigned FLUSH_GO_BIT   = 20;
  localparam int unsigned FLUSH_BUSY_BIT = 2;
  localparam int unsigned CTRL_XLATE_BIT = 7;
  localparam int unsigned CTRL_BYPX_BIT  = 8;
  localparam int unsigned CTRL_BYPP_BIT  = 12;

  typedef struct packed {
    logic bypp;
    logic bypx;
    logic xlate;
  } ctrl_t;
endpackage

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_pkg::*;
#(
  parameter int unsigned NSTREAM = XS_NSTREAM,
  localparam int unsigned SIDW = $clog2(NSTREAM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SIDW-1:0]    wr_sid,
  input  ctrl_t              wr_val,
  input  logic [SIDW-1:0]    rd_sid,
  output ctrl_t              rd_val,
  output logic [NSTREAM-1:0] xlate_en,
  output logic [NSTREAM-1:0] bypass_xlate,
  output logic [NSTREAM-1:0] bypass_pref
);
  ctrl_t ctrl_q [NSTREAM];

  for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[s] <= '0;
      else if (wr_en && (wr_sid == SIDW'(s))) ctrl_q[s] <= wr_val;
    end
    assign xlate_en[s]     = ctrl_q[s].xlate;
    assign bypass_xlate[s] = ctrl_q[s].bypx;
    assign bypass_pref[s]  = ctrl_q[s].bypp;
  end

  assign rd_val = ctrl_q[rd_sid];

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(xlate_en) && $stable(bypass_xlate) && $stable(bypass_pref)); // R2
endmodule

// File: rtl/xlat_base_regs.sv
module xlat_base_regs
  import xlat_pkg::*;
#(
  parameter int unsigned NENT = XS_NSTREAM * XS_NBASE,
  parameter int unsigned DW   = XS_DW,
  localparam int unsigned EW  = $clog2(NENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [EW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_val,
  input  logic [EW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_val,
  output logic [NENT*DW-1:0] base_flat
);
  logic [DW-1:0] ent_q [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[e] <= '0;
      else if (wr_en && (wr_idx == EW'(e))) ent_q[e] <= wr_val;
    end
    assign base_flat[e*DW +: DW] = ent_q[e];
  end

  assign rd_val = ent_q[rd_idx];

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_flat)); // R3
endmodule

// File: rtl/xlat_flush_ctl.sv
module xlat_flush_ctl
  import xlat_pkg::*;
#(
  parameter int unsigned NSTREAM = XS_NSTREAM
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NSTREAM-1:0] mask_in,
  input  logic               inv_done,
  output logic               busy,
  output logic               inv_req,
  output logic [NSTREAM-1:0] inv_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      inv_req  <= 1'b0;
      inv_mask <= '0;
    end else begin
      inv_req <= 1'b0;
      if (!busy && start) begin
        busy     <= 1'b1;
        inv_req  <= 1'b1;
        inv_mask <= mask_in;
      end else if (busy && inv_done) begin
        busy <= 1'b0;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> !inv_req); // R6
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> busy); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !inv_done |=> busy); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && inv_done |=> !busy); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !inv_req && $stable(inv_mask)); // R8
endmodule

// File: rtl/xlat_stream_regs.sv
module xlat_stream_regs
  import xlat_pkg::*;
#(
  parameter int unsigned NSTREAM = XS_NSTREAM,
  parameter int unsigned NBASE   = XS_NBASE,
  parameter int unsigned DW      = XS_DW,
  parameter int unsigned AW      = XS_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_bypass_ok,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DW-1:0]            rsp_rdata,
  output logic [NSTREAM-1:0]       xlate_en,
  output logic [NSTREAM-1:0]       bypass_xlate,
  output logic [NSTREAM-1:0]       bypass_pref,
  output logic [NSTREAM-1:0]       stream_en,
  output logic [NSTREAM*NBASE*DW-1:0] base_flat,
  output logic                     inv_req,
  output logic [NSTREAM-1:0]       inv_mask,
  input  logic                     inv_done
);
  localparam int unsigned NENT   = NSTREAM * NBASE;
  localparam int unsigned SIDW   = $clog2(NSTREAM);
  localparam int unsigned EW     = $clog2(NENT);
  localparam int unsigned WW     = AW - 2;
  localparam int unsigned W_CTRL = OFF_CTRL >> 2;
  localparam int unsigned W_BASE = OFF_BASE >> 2;

  logic          acc, aligned;
  logic [WW-1:0] widx;
  logic          hit_param, hit_cmd, hit_mask, hit_sen, hit_ctrl, hit_base;
  logic [SIDW-1:0] sid;
  logic [EW-1:0]   eidx;
  logic [DW-1:0]   rdata;
  logic [NSTREAM-1:0] mask_q, sen_q;
  logic            busy;
  ctrl_t           ctrl_wv, ctrl_rv;
  logic [DW-1:0]   base_rv;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign widx      = req_addr[AW-1:2];

  assign hit_param = aligned && (int'(widx) == int'(OFF_PARAM >> 2));
  assign hit_cmd   = aligned && (int'(widx) == int'(OFF_FLUSH_CMD >> 2));
  assign hit_mask  = aligned && (int'(widx) == int'(OFF_FLUSH_MASK >> 2));
  assign hit_sen   = aligned && (int'(widx) == int'(OFF_STREAM_EN >> 2));
  assign hit_ctrl  = aligned && (int'(widx) >= int'(W_CTRL)) &&
                     (int'(widx) < int'(W_CTRL + NSTREAM));
  assign hit_base  = aligned && (int'(widx) >= int'(W_BASE)) &&
                     (int'(widx) < int'(W_BASE + NENT));
  assign sid  = SIDW'(int'(widx) - int'(W_CTRL));
  assign eidx = EW'(int'(widx) - int'(W_BASE));

  assign ctrl_wv.xlate = req_wdata[CTRL_XLATE_BIT];
  assign ctrl_wv.bypx  = req_wdata[CTRL_BYPX_BIT];
  assign ctrl_wv.bypp  = req_wdata[CTRL_BYPP_BIT];

  xlat_ctrl_regs #(.NSTREAM(NSTREAM)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && req_write && hit_ctrl), .wr_sid(sid), .wr_val(ctrl_wv),
    .rd_sid(sid), .rd_val(ctrl_rv),
    .xlate_en(xlate_en), .bypass_xlate(bypass_xlate), .bypass_pref(bypass_pref)
  );

  xlat_base_regs #(.NENT(NENT), .DW(DW)) u_base (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && req_write && hit_base), .wr_idx(eidx), .wr_val(req_wdata),
    .rd_idx(eidx), .rd_val(base_rv), .base_flat(base_flat)
  );

  xlat_flush_ctl #(.NSTREAM(NSTREAM)) u_flush (
    .clk(clk), .rst_n(rst_n),
    .start(acc && req_write && hit_cmd && req_wdata[FLUSH_GO_BIT]),
    .mask_in(mask_q), .inv_done(inv_done),
    .busy(busy), .inv_req(inv_req), .inv_mask(inv_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sen_q  <= '0;
    end else if (acc && req_write) begin
      if (hit_mask) mask_q <= req_wdata[NSTREAM-1:0];
      if (hit_sen)  sen_q  <= req_wdata[NSTREAM-1:0];
    end
  end
  assign stream_en = sen_q;

  always_comb begin
    rdata = '0;
    if (hit_param) rdata[0] = cfg_bypass_ok;
    if (hit_cmd)   rdata[FLUSH_BUSY_BIT] = busy;
    if (hit_mask)  rdata[NSTREAM-1:0] = mask_q;
    if (hit_sen)   rdata[NSTREAM-1:0] = sen_q;
    if (hit_ctrl) begin
      rdata[CTRL_XLATE_BIT] = ctrl_rv.xlate;
      rdata[CTRL_BYPX_BIT]  = ctrl_rv.bypx;
      rdata[CTRL_BYPP_BIT]  = ctrl_rv.bypp;
    end
    if (hit_base)  rdata = base_rv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (acc && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rdata;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
endmodule

// File: tb/xlat_stream_regs_tb.sv
module xlat_stream_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cfg_bypass_ok = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, inv_done = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, inv_req;
  logic [31:0] rsp_rdata;
  logic [15:0] xlate_en, bypass_xlate, bypass_pref, stream_en, inv_mask;
  logic [2047:0] base_flat;

  xlat_stream_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bypass_ok(cfg_bypass_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .xlate_en(xlate_en), .bypass_xlate(bypass_xlate), .bypass_pref(bypass_pref),
    .stream_en(stream_en), .base_flat(base_flat),
    .inv_req(inv_req), .inv_mask(inv_mask), .inv_done(inv_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_err = 0;
  bit stall = 1'b0;
  int stall_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each consumed response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) chk(1'b0, "R11 unexpected response", rsp_rdata, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_rdata === e.v, e.tag, rsp_rdata, e.v);
      end
    end
    stall_cnt++;
    rsp_ready <= stall ? (stall_cnt % 3 == 0) : 1'b1;
  end

  task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    xfer(1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag;
    sb.push_back(e);
    xfer(1'b0, a, 32'h0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(xlate_en == 0 && bypass_xlate == 0 && bypass_pref == 0, "R1 ctrl outputs", {16'h0, xlate_en}, 0);
    chk(stream_en == 0 && inv_mask == 0 && !inv_req, "R1 enable/inv", {stream_en, inv_mask}, 0);
    chk(base_flat == '0, "R1 bases", base_flat[31:0], 0);
    rd(12'h004, 32'h1, "R1 param reads strap");
    rd(12'h020, 32'h0, "R1 flush idle");

    // R2 control words
    wr(12'h10C, 32'hFFFF_FFFF);
    chk(xlate_en == 16'h0008 && bypass_xlate == 16'h0008 && bypass_pref == 16'h0008,
        "R2 sid3 outputs", {16'h0, xlate_en}, 32'h8);
    rd(12'h10C, 32'h0000_1180, "R2 sid3 readback");
    wr(12'h13C, 32'h0000_0080);
    chk(xlate_en == 16'h8008 && bypass_xlate == 16'h0008, "R2 sid15 translate only", {16'h0, xlate_en}, 32'h8008);
    wr(12'h10C, 32'h0);
    chk(xlate_en == 16'h8000 && bypass_xlate == 0 && bypass_pref == 0, "R2 zero disables", {16'h0, xlate_en}, 32'h8000);

    // R3 base entries
    wr(12'h258, 32'h8001_2345);
    chk(base_flat[22*32 +: 32] == 32'h8001_2345, "R3 sid5 idx2 output", base_flat[22*32 +: 32], 32'h8001_2345);
    wr(12'h2FC, 32'hDEAD_BEEF);
    chk(base_flat[63*32 +: 32] == 32'hDEAD_BEEF, "R3 last entry output", base_flat[63*32 +: 32], 32'hDEAD_BEEF);
    rd(12'h258, 32'h8001_2345, "R3 readback");
    wr(12'h258, 32'h0);
    rd(12'h258, 32'h0, "R3 zero invalidates");

    // R4 stream enable
    wr(12'h0FC, 32'h1234_5678);
    chk(stream_en == 16'h5678, "R4 output", {16'h0, stream_en}, 32'h5678);
    rd(12'h0FC, 32'h0000_5678, "R4 readback");

    // R9 param read-only
    wr(12'h004, 32'h0);
    rd(12'h004, 32'h1, "R9 write ignored");
    drain();
    cfg_bypass_ok = 1'b0;
    rd(12'h004, 32'h0, "R9 follows strap");

    // R10 unmapped
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h10D, 32'hFFFF_FFFF);
    chk(xlate_en == 16'h8000 && bypass_pref == 0, "R10 unaligned write ignored", {16'h0, xlate_en}, 32'h8000);
    rd(12'h008, 32'h0, "R10 unmapped 0x008");
    rd(12'h300, 32'h0, "R10 unmapped 0x300");
    rd(12'h13D, 32'h0, "R10 unaligned read");

    // R5/R6 flush start
    wr(12'h034, 32'hFFFF_00A5);
    rd(12'h034, 32'h0000_00A5, "R5 mask readback");
    wr(12'h020, 32'h0010_0000);
    chk(inv_req === 1'b1 && inv_mask == 16'h00A5, "R6 R5 pulse with mask", {15'h0, inv_req, inv_mask}, 32'h1_00A5);
    @(negedge clk); #1;
    chk(inv_req === 1'b0, "R6 pulse one cycle", {31'h0, inv_req}, 0);
    rd(12'h020, 32'h4, "R6 busy set");

    // R8 restart while busy
    wr(12'h034, 32'h0000_FFFF);
    wr(12'h020, 32'h0010_0000);
    chk(inv_req === 1'b0, "R8 no second pulse", {31'h0, inv_req}, 0);
    @(negedge clk); #1;
    chk(inv_req === 1'b0 && inv_mask == 16'h00A5, "R8 mask kept", {15'h0, inv_req, inv_mask}, 32'h00A5);
    rd(12'h020, 32'h4, "R8 still busy");
    drain();

    // R7 completion
    @(negedge clk); inv_done = 1'b1;
    @(negedge clk); inv_done = 1'b0;
    rd(12'h020, 32'h0, "R7 busy cleared");
    drain();
    @(negedge clk); inv_done = 1'b1;
    @(negedge clk); inv_done = 1'b0;
    rd(12'h020, 32'h0, "R7 idle done ignored");
    wr(12'h020, 32'h0010_0000);
    chk(inv_req === 1'b1 && inv_mask == 16'hFFFF, "R7 R5 new flush after clear", {15'h0, inv_req, inv_mask}, 32'h1_FFFF);
    @(negedge clk); inv_done = 1'b1;
    @(negedge clk); inv_done = 1'b0;

    // R11 back-pressure and ordering
    drain();
    stall = 1'b1;
    rd(12'h0FC, 32'h0000_5678, "R11 stalled read 1");
    rd(12'h13C, 32'h0000_0080, "R11 stalled read 2");
    rd(12'h2FC, 32'hDEAD_BEEF, "R11 stalled read 3");
    rd(12'h034, 32'h0000_FFFF, "R11 stalled read 4");
    drain();
    stall = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule